// File: doc/BRIEF.md
# Shadowed Nonvolatile Configuration Store

This block holds a small bank of configuration registers. Each one has a volatile shadow copy, which the logic reads, and a nonvolatile copy, which survives power loss. A host reaches the bank over a plain register bus with a write strobe, a read strobe, an address and data. A single mode bit in a separate control register chooses how host writes behave. With the bit clear, a write updates the shadow and also commits to the nonvolatile copy. The commit holds a busy flag for a fixed number of cycles. With the bit set, a write updates only the shadow. There is then no commit wait and no wear.

Reset stands for a power cycle. On reset a load sequencer copies every nonvolatile location into its shadow. The ready flag stays low until that copy is finished. While ready is low, and while a commit is in progress, writes are refused and an error pulse is raised. Reads always return the shadow. The nonvolatile array is a behavioural model with an adjustable commit time. Its contents are not cleared by reset, so it retains the values last committed.

Top module: `nvs_store`

## Requirements
- R1: After reset is released, the load sequencer copies each nonvolatile location into its shadow, then raises `ready`. `ready` stays high until the next reset. Unwritten locations hold INIT_BASE plus their index (0x40 + i by default).
- R2: The control register sits at the highest address, 0xF by default. Its bit 7 is the mode bit. Every reset clears the mode bit, because the control register has no nonvolatile copy. A read of the control register returns the mode bit in bit 7 and zeros in all other bits.
- R3: In mode 0 (bit 7 clear), an accepted write to a location updates the shadow and commits the value to the nonvolatile copy. `busy` is high for exactly COMMIT_CYC cycles, starting the cycle after the write.
- R4: In mode 1 (bit 7 set), an accepted write updates only the shadow. `busy` stays low.
- R5: A write that arrives while `busy` is high, or while `ready` is low, is refused. The refused write changes no shadow, no nonvolatile copy and not the control register. `err` is high for one cycle, on the cycle after the refused write.
- R6: A read returns the shadow value in either mode, including while `busy` is high. `rd_valid` and `rdata` appear the cycle after `rd_en`. A read of an address with no register behind it returns 0.
- R7: After a reset, each location holds the last value committed in mode 0. Values written in mode 1 are gone.
- R8: In mode 1, writes may be issued on every cycle without limit. Each one is accepted and none raises `err`.
- R9: A write to an address between NUM_LOC and the control address is ignored. It raises neither `busy` nor `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| busy | output | 1 | Nonvolatile commit in progress |
| ready | output | 1 | Power-up load finished |
| err | output | 1 | One-cycle pulse for a refused write |

## Verification
Assertions check the following on every cycle:
- a committing write is followed by `busy`;
- a volatile-mode write never raises `busy`;
- a write during `busy` is followed by `err`;
- the commit timer is never restarted while it is running;
- `ready` never drops without reset;
- the mode bit is clear after every reset.

The bench scenarios cover what spans a power cycle:
- that committed values come back after a reset and volatile ones do not;
- the exact length of `busy`;
- that refused writes leave no trace in later reads;
- that a long run of volatile writes never errors.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    LD_RUN  = 2'd0,
    LD_LAST = 2'd1,
    LD_DONE = 2'd2
  } ld_state_t;
endpackage

// File: rtl/nvs_nvarray.sv
module nvs_nvarray #(
  parameter int NUM_LOC = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT_BASE = 8'h40,
  localparam int IDX_W = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  // Contents survive reset: this models the persistent cells.
  logic [DATA_W-1:0] mem [NUM_LOC];

  initial begin
    for (int i = 0; i < NUM_LOC; i++) mem[i] = INIT_BASE + DATA_W'(i);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvs_commit_timer.sv
module nvs_commit_timer #(
  parameter int COMMIT_CYC = 16,
  localparam int CNT_W = $clog2(COMMIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start) cnt <= CNT_W'(COMMIT_CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> (cnt == '0)); // R5
endmodule

// File: rtl/nvs_loader.sv
module nvs_loader import nvs_pkg::*; #(
  parameter int NUM_LOC = 8,
  localparam int IDX_W = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] rd_idx,
  output logic             sh_we,
  output logic [IDX_W-1:0] sh_idx,
  output logic             ready
);
  ld_state_t        st;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= LD_RUN;
      idx <= '0;
      sh_idx <= '0;
      sh_we <= 1'b0;
      ready <= 1'b0;
    end else begin
      case (st)
        LD_RUN: begin
          sh_we <= 1'b1;
          sh_idx <= idx;
          if (idx == IDX_W'(NUM_LOC - 1)) st <= LD_LAST;
          else idx <= idx + 1'b1;
        end
        LD_LAST: begin
          sh_we <= 1'b0;
          ready <= 1'b1;
          st <= LD_DONE;
        end
        default: begin
          sh_we <= 1'b0;
        end
      endcase
    end
  end

  assign rd_idx = idx;

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R1
endmodule

// File: rtl/nvs_store.sv
module nvs_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NUM_LOC = 8,
  parameter int COMMIT_CYC = 16,
  parameter logic [DATA_W-1:0] INIT_BASE = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              busy,
  output logic              ready,
  output logic              err
);
  localparam int IDX_W = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W:0] LOC_LIM = (ADDR_W+1)'(NUM_LOC);
  localparam int MODE_BIT = 7;

  logic [DATA_W-1:0] shadow [NUM_LOC];
  logic              mode_q;
  logic              hit_loc, hit_ctrl, acc_wr, rej_wr, nv_we;
  logic [IDX_W-1:0]  loc_idx, ld_rd_idx, ld_sh_idx;
  logic              ld_we;
  logic [DATA_W-1:0] nv_rdata;

  assign hit_loc  = ({1'b0, addr} < LOC_LIM);
  assign hit_ctrl = (addr == CTRL_ADDR);
  assign loc_idx  = addr[IDX_W-1:0];
  assign acc_wr   = wr_en && ready && !busy;
  assign rej_wr   = wr_en && !(ready && !busy);
  assign nv_we    = acc_wr && hit_loc && !mode_q;

  nvs_loader #(.NUM_LOC(NUM_LOC)) u_loader (
    .clk(clk), .rst(rst), .rd_idx(ld_rd_idx),
    .sh_we(ld_we), .sh_idx(ld_sh_idx), .ready(ready)
  );

  nvs_nvarray #(.NUM_LOC(NUM_LOC), .DATA_W(DATA_W), .INIT_BASE(INIT_BASE)) u_nv (
    .clk(clk), .we(nv_we), .waddr(loc_idx), .wdata(wdata),
    .raddr(ld_rd_idx), .rdata(nv_rdata)
  );

  nvs_commit_timer #(.COMMIT_CYC(COMMIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(nv_we), .busy(busy)
  );

  // Shadow bank: filled by the loader, then by accepted host writes.
  always_ff @(posedge clk) begin
    if (ld_we) shadow[ld_sh_idx] <= nv_rdata;
    else if (acc_wr && hit_loc) shadow[loc_idx] <= wdata;
  end

  // Mode register: volatile only, cleared by every reset.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else if (acc_wr && hit_ctrl) mode_q <= wdata[MODE_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else err <= rej_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rdata <= '0;
    end else begin
      rd_valid <= rd_en && ready;
      if (rd_en && ready) begin
        if (hit_loc) rdata <= shadow[loc_idx];
        else if (hit_ctrl) rdata <= DATA_W'({mode_q, 7'b0});
        else rdata <= '0;
      end
    end
  end

  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (rst)
    nv_we |=> busy); // R3
  AST_VOL_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && mode_q) |=> !busy); // R4
  AST_ERR_REJECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> err); // R5
  AST_MODE_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> !mode_q); // R2
endmodule

// File: tb/tb_nvs_store.sv
module tb_nvs_store;
  localparam int AW = 4, DW = 8, NL = 8, CC = 12;
  localparam logic [7:0] IB = 8'h40;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_valid, busy, ready, err;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic seen_err, seen_busy;

  nvs_store #(.ADDR_W(AW), .DATA_W(DW), .NUM_LOC(NL), .COMMIT_CYC(CC), .INIT_BASE(IB)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .busy(busy), .ready(ready), .err(err)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data as results appear.
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) chk("R6 unexpected rd_valid", 1, 0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    seen_err = err; seen_busy = busy;
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * CC && busy; i++) @(negedge clk);
  endtask

  task automatic power_cycle();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 4 * NL) begin @(negedge clk); n++; end
    chk("R1 ready after load", ready, 1);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset ready low", ready, 0);
    chk("R3 reset busy low", busy, 0);
    rst = 0;
    wr(0, 8'hFF);
    chk("R5 err for write before ready", seen_err, 1);
    wait_ready();
    for (int i = 0; i < NL; i++) rd(AW'(i), IB + 8'(i), "R1 loaded init value");
    rd(4'hF, 8'h00, "R2 mode clear after reset");
    rd(4'h9, 8'h00, "R6 unmapped read");

    wr(2, 8'hA5);
    chk("R3 no err on commit", seen_err, 0);
    n = 0;
    while (busy && n < 4 * CC) begin n++; @(negedge clk); end
    chk("R3 busy length", n, CC);
    rd(2, 8'hA5, "R6 read committed value");

    wr(3, 8'h11);
    wr(4, 8'h22);
    chk("R5 err on write while busy", seen_err, 1);
    wr(4'hF, 8'h80);
    chk("R5 err on ctrl write while busy", seen_err, 1);
    rd(3, 8'h11, "R6 read while busy");
    wait_idle();
    rd(4, IB + 8'd4, "R5 refused write left shadow");
    rd(4'hF, 8'h00, "R5 refused ctrl write");

    wr(4'hF, 8'hFF);
    rd(4'hF, 8'h80, "R2 mode bit only");
    wr(2, 8'h3C);
    chk("R4 no busy in volatile mode", seen_busy, 0);
    chk("R4 no err in volatile mode", seen_err, 0);
    rd(2, 8'h3C, "R6 volatile value read");

    @(negedge clk);
    wr_en = 1; addr = 5;
    for (int i = 0; i < 10; i++) begin
      wdata = 8'(8'hC0 + i);
      @(negedge clk);
      chk("R8 back-to-back no err", err, 0);
      chk("R8 back-to-back no busy", busy, 0);
    end
    wr_en = 0;
    rd(5, 8'hC9, "R8 last burst value");

    power_cycle();
    wait_ready();
    rd(2, 8'hA5, "R7 committed value restored");
    rd(5, IB + 8'd5, "R7 volatile value lost");
    rd(3, 8'h11, "R7 second commit restored");
    rd(4'hF, 8'h00, "R2 mode cleared by reset");

    wr(4'hA, 8'h77);
    chk("R9 unmapped write no busy", seen_busy, 0);
    chk("R9 unmapped write no err", seen_err, 0);
    rd(4'hA, 8'h00, "R9 unmapped still zero");
    wr(7, 8'h99);
    wait_idle();
    power_cycle();
    wait_ready();
    rd(7, 8'h99, "R7 commit after reset restored");

    repeat (3) @(negedge clk);
    chk("R6 all reads returned", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule